// File: doc/BRIEF.md
# Paired-Clock Multi-Channel PWM Bank

The block drives a set of pulse-width-modulated outputs from a small write/read register port. Two clock sources enter as one-cycle tick pulses. Each pair of neighbouring channels picks one of these sources and divides it by a power of two. Each channel then divides the result again by its own 8-bit prescaler. It also runs a 16-bit period counter with a programmable active count and a programmable active level.

A channel counts only while its gate bit and its enable bit are both set. Software programs the pair clock word and the two per-channel words, then sets the gate and enable bits. Rewriting a running channel drops the period in progress and starts a new one at once. The outputs change in the cycle after the write.

Top module: `pwm_bank`

## Requirements
- R1: After reset, every register reads as zero and every output is high, because the active-level bit resets to 0 (active low).
- R2: The pair clock word at address 0x20 + 4*(ch>>1) is shared by channels 2n and 2n+1, so a write to it changes the timing of both channels.
- R3: The period word at 0x104 + 0x20*ch holds the last count in bits 31:16 (period = value + 1 steps) and the active count in bits 15:0. The output is active while the counter is below the active count.
- R4: Control word bits 7:0 hold K. The period counter advances once every K+1 divided ticks.
- R5: Pair clock bits 3:0 hold an exponent M. The selected source is divided by 2^M, and any M above 8 acts as 8.
- R6: Pair clock bit 7 picks the tick source: 0 selects src_tick[0] and 1 selects src_tick[1].
- R7: Control word bit 8 is the active output level. The inactive level is its inverse.
- R8: An active count of 0 keeps the output inactive for the whole period. An active count of at least the period keeps it active for the whole period.
- R9: The enable word at 0x80 holds one bit per channel at bit position ch. With its bit clear, a channel drives the inactive level and the other channels run on.
- R10: The gate word at 0x40 holds one bit per channel at bit position ch. A channel counts only while both its gate and enable bits are set. Otherwise its counter is held at zero and its output is inactive, so a channel restarts from the start of a period when it runs again.
- R11: A write to a channel's control word, its period word, or its pair clock word restarts that channel's period in the same edge. The output is at the active level in the cycle after the write.
- R12: Reads return the last value written, masked to the implemented bits: pair word 0x8F, gate and enable the low NUM_CH bits, control word 0x1FF, period word all 32 bits. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the register at addr |
| addr | input | ADDR_W | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| src_tick | input | 2 | One-cycle tick pulses of the two clock sources |
| pwm_out | output | NUM_CH | Channel outputs |

## Verification
A register write lands on the edge that takes the strobe, and rdata reflects it from the next sample. The counter steps on the edge where the divided tick and the prescaler match coincide, and the output follows the counter combinationally. A restart therefore shows the active level at the first sample after the write edge. The active run lasts exactly active count × 2^M × (K+1) cycles. The duty checks count samples taken on falling edges over a window of a whole number of periods, so the phase at which the window starts does not affect the expected count. The restart and re-gate checks count the run of consecutive active samples starting with the sample right after the write.

// File: rtl/pwm_bank_pkg.sv
// Shared address map and field widths of the PWM bank.
// Assumes byte addresses and 32-bit register words.
package pwm_bank_pkg;
    localparam int unsigned PAIR_BASE   = 32'h020;
    localparam int unsigned PAIR_STRIDE = 32'h004;
    localparam int unsigned GATE_ADDR   = 32'h040;
    localparam int unsigned EN_ADDR     = 32'h080;
    localparam int unsigned CH_BASE     = 32'h100;
    localparam int unsigned CH_STRIDE   = 32'h020;
    localparam int unsigned PER_OFS     = 32'h004;
    localparam int unsigned SEL_BIT     = 7;
    localparam int unsigned EXP_W       = 4;
    localparam int unsigned DIV_MAX     = 8;
    localparam int unsigned PRE_W       = 8;
    localparam int unsigned CNT_W       = 16;
    localparam int unsigned POL_BIT     = PRE_W;
endpackage

// File: rtl/pwm_regs.sv
// Register file of the PWM bank: stores the pair clock words, gate and
// enable bits and per-channel control/period words. It returns the masked
// contents on reads and flags a restart for every channel whose
// configuration is written. Assumes single-cycle writes.
module pwm_regs
    import pwm_bank_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 12,
    localparam int unsigned NUM_PAIR = (NUM_CH + 1) / 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [31:0]               wdata,
    output logic [31:0]               rdata,
    output logic [NUM_PAIR-1:0]       pair_sel,
    output logic [NUM_PAIR*EXP_W-1:0] pair_exp,
    output logic [NUM_CH-1:0]         gate,
    output logic [NUM_CH-1:0]         en,
    output logic [NUM_CH-1:0]         pol,
    output logic [NUM_CH*PRE_W-1:0]   pre,
    output logic [NUM_CH*CNT_W-1:0]   last,
    output logic [NUM_CH*CNT_W-1:0]   act,
    output logic [NUM_CH-1:0]         restart
);

    logic [NUM_PAIR-1:0] pair_hit;
    logic [NUM_CH-1:0]   ctl_hit;
    logic [NUM_CH-1:0]   per_hit;
    logic                unused_wbits;

    assign unused_wbits = ^{wdata[31:POL_BIT+1], wdata[6:EXP_W]};

    // Decode the pair clock words.
    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        assign pair_hit[p] = wr_en && (addr == ADDR_W'(PAIR_BASE + p * PAIR_STRIDE));

        // Store one pair clock word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pair_sel[p]                 <= 1'b0;
                pair_exp[p*EXP_W +: EXP_W]  <= '0;
            end else if (pair_hit[p]) begin
                pair_sel[p]                 <= wdata[SEL_BIT];
                pair_exp[p*EXP_W +: EXP_W]  <= wdata[EXP_W-1:0];
            end
        end
    end

    // Decode, store and restart each channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ctl_hit[c] = wr_en && (addr == ADDR_W'(CH_BASE + c * CH_STRIDE));
        assign per_hit[c] = wr_en && (addr == ADDR_W'(CH_BASE + c * CH_STRIDE + PER_OFS));
        assign restart[c] = ctl_hit[c] || per_hit[c] || pair_hit[c/2];

        // Store the channel control word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pol[c]                  <= 1'b0;
                pre[c*PRE_W +: PRE_W]   <= '0;
            end else if (ctl_hit[c]) begin
                pol[c]                  <= wdata[POL_BIT];
                pre[c*PRE_W +: PRE_W]   <= wdata[PRE_W-1:0];
            end
        end

        // Store the channel period word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                last[c*CNT_W +: CNT_W]  <= '0;
                act[c*CNT_W +: CNT_W]   <= '0;
            end else if (per_hit[c]) begin
                last[c*CNT_W +: CNT_W]  <= wdata[2*CNT_W-1:CNT_W];
                act[c*CNT_W +: CNT_W]   <= wdata[CNT_W-1:0];
            end
        end
    end

    // Store the gate and enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate <= '0;
            en   <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(GATE_ADDR)) gate <= wdata[NUM_CH-1:0];
            if (addr == ADDR_W'(EN_ADDR))   en   <= wdata[NUM_CH-1:0];
        end
    end

    // Read multiplexer with unused bits forced to zero.
    always_comb begin
        rdata = '0;
        for (int p = 0; p < int'(NUM_PAIR); p++) begin
            if (addr == ADDR_W'(PAIR_BASE + p * PAIR_STRIDE)) begin
                rdata[SEL_BIT]     = pair_sel[p];
                rdata[EXP_W-1:0]   = pair_exp[p*EXP_W +: EXP_W];
            end
        end
        if (addr == ADDR_W'(GATE_ADDR)) rdata[NUM_CH-1:0] = gate;
        if (addr == ADDR_W'(EN_ADDR))   rdata[NUM_CH-1:0] = en;
        for (int c = 0; c < int'(NUM_CH); c++) begin
            if (addr == ADDR_W'(CH_BASE + c * CH_STRIDE)) begin
                rdata[POL_BIT]     = pol[c];
                rdata[PRE_W-1:0]   = pre[c*PRE_W +: PRE_W];
            end
            if (addr == ADDR_W'(CH_BASE + c * CH_STRIDE + PER_OFS)) begin
                rdata = {last[c*CNT_W +: CNT_W], act[c*CNT_W +: CNT_W]};
            end
        end
    end

    AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(EN_ADDR)) |=> en == $past(wdata[NUM_CH-1:0])); // R9

endmodule

// File: rtl/pwm_pair_div.sv
// Clock divider for one channel pair: selects one of two tick sources and
// emits every 2^M-th selected tick, with M limited to DIV_MAX. A restart
// clears the phase. Assumes the source ticks are one-cycle pulses.
module pwm_pair_div
    import pwm_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       src_tick,
    input  logic             sel,
    input  logic [EXP_W-1:0] exp_in,
    input  logic             restart,
    output logic             div_tick
);

    logic [DIV_MAX-1:0] phase;
    logic [EXP_W-1:0]   eff_exp;
    logic [DIV_MAX:0]   mask_w;
    logic               src;

    assign src     = sel ? src_tick[1] : src_tick[0];
    assign eff_exp = (exp_in > EXP_W'(DIV_MAX)) ? EXP_W'(DIV_MAX) : exp_in;
    assign mask_w  = ((DIV_MAX+1)'(1) << eff_exp) - (DIV_MAX+1)'(1);
    assign div_tick = src && ((phase & mask_w[DIV_MAX-1:0]) == mask_w[DIV_MAX-1:0]);

    // Count selected source ticks; a restart realigns the phase.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) phase <= '0;
        else if (src)          phase <= phase + 1'b1;
    end

    AST_DIV_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (div_tick && eff_exp != '0 && !restart) |=> !div_tick); // R5

endmodule

// File: rtl/pwm_chan.sv
// One PWM channel: a prescaler over the divided pair tick feeding a period
// counter. The output is the active level while the count is below the
// active count. Assumes that every configuration change arrives with restart.
module pwm_chan
    import pwm_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_tick,
    input  logic             run,
    input  logic             restart,
    input  logic             pol,
    input  logic [PRE_W-1:0] pre,
    input  logic [CNT_W-1:0] last,
    input  logic [CNT_W-1:0] act,
    output logic             out
);

    logic [PRE_W-1:0] pc;
    logic [CNT_W-1:0] cnt;

    // Advance prescaler and period counter; hold both at zero when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            pc  <= '0;
            cnt <= '0;
        end else if (div_tick) begin
            if (pc == pre) begin
                pc  <= '0;
                cnt <= (cnt == last) ? '0 : cnt + 1'b1;
            end else begin
                pc  <= pc + 1'b1;
            end
        end
    end

    assign out = (run && cnt < act) ? pol : ~pol;

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0 && pc == '0)); // R11
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last); // R3
    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && !div_tick) |=> $stable(cnt)); // R4
    AST_STOPPED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0); // R10

endmodule

// File: rtl/pwm_bank.sv
// Top of the PWM bank: register file, one divider per channel pair and one
// counter per channel. Assumes src_tick pulses are synchronous to clk.
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [1:0]        src_tick,
    output logic [NUM_CH-1:0] pwm_out
);

    localparam int unsigned NUM_PAIR = (NUM_CH + 1) / 2;

    logic [NUM_PAIR-1:0]       pair_sel;
    logic [NUM_PAIR*EXP_W-1:0] pair_exp;
    logic [NUM_PAIR-1:0]       pair_tick;
    logic [NUM_PAIR-1:0]       pair_restart;
    logic [NUM_CH-1:0]         gate, en, pol, restart;
    logic [NUM_CH*PRE_W-1:0]   pre;
    logic [NUM_CH*CNT_W-1:0]   last, act;

    pwm_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pair_sel(pair_sel), .pair_exp(pair_exp),
        .gate(gate), .en(en), .pol(pol), .pre(pre), .last(last), .act(act),
        .restart(restart)
    );

    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        assign pair_restart[p] = wr_en && (addr == ADDR_W'(PAIR_BASE + p * PAIR_STRIDE));
        pwm_pair_div u_div (
            .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .sel(pair_sel[p]),
            .exp_in(pair_exp[p*EXP_W +: EXP_W]), .restart(pair_restart[p]),
            .div_tick(pair_tick[p])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm_chan u_chan (
            .clk(clk), .rst_n(rst_n), .div_tick(pair_tick[c/2]),
            .run(gate[c] && en[c]), .restart(restart[c]), .pol(pol[c]),
            .pre(pre[c*PRE_W +: PRE_W]), .last(last[c*CNT_W +: CNT_W]),
            .act(act[c*CNT_W +: CNT_W]), .out(pwm_out[c])
        );
    end

endmodule

// File: tb/tb_pwm_bank.sv
// Directed bench for pwm_bank: one task per scenario, each checking itself.
module tb_pwm_bank;
    localparam int NCH = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [11:0]     addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            tog = 1'b0;
    logic [1:0]      src_tick;
    logic [NCH-1:0]  pwm_out;
    int              errs = 0;
    int              checks = 0;

    always #2 clk = ~clk;
    always @(negedge clk) tog <= ~tog;
    assign src_tick = {tog, 1'b1};

    pwm_bank #(.NUM_CH(NCH), .ADDR_W(12)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .src_tick(src_tick), .pwm_out(pwm_out)
    );

    function automatic logic [11:0] pair_a(int ch); return 12'h020 + 12'(4 * (ch >> 1)); endfunction
    function automatic logic [11:0] ctl_a(int ch);  return 12'h100 + 12'(32 * ch); endfunction
    function automatic logic [11:0] per_a(int ch);  return 12'h104 + 12'(32 * ch); endfunction

    task automatic check(input string req, input longint act_v, input longint exp_v);
        checks++;
        if (act_v != exp_v) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] e);
        @(negedge clk); addr = a; #1;
        check(req, rdata, e);
    endtask

    task automatic cfg(input int ch, input bit pl, input int k, input int lst, input int ac);
        wr(ctl_a(ch), {23'd0, pl, 8'(k)});
        wr(per_a(ch), {16'(lst), 16'(ac)});
    endtask

    task automatic count_high(input int ch, input int n, output int h);
        h = 0;
        repeat (n) begin @(negedge clk); if (pwm_out[ch]) h++; end
    endtask

    task automatic run_len(input int ch, input bit lvl, output int n);
        n = 0;
        while (pwm_out[ch] == lvl && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    task automatic t_reset;
        check("R1 outputs after reset", pwm_out, 4'hF);
        rd_check("R1 enable word after reset", 12'h080, 0);
        rd_check("R1 period word after reset", per_a(1), 0);
    endtask

    task automatic t_duty;
        int h;
        wr(12'h040, 32'hF); wr(12'h080, 32'hF);
        cfg(0, 1, 0, 9, 3);
        repeat (5) @(negedge clk);
        count_high(0, 40, h);
        check("R3 duty 3 of 10", h, 12);
    endtask

    task automatic t_prescale;
        int h;
        cfg(1, 1, 2, 3, 1);
        repeat (5) @(negedge clk);
        count_high(1, 48, h);
        check("R4 prescaler K=2", h, 12);
    endtask

    task automatic t_divider;
        int h;
        wr(pair_a(2), 32'h2);
        cfg(2, 1, 0, 3, 2);
        repeat (5) @(negedge clk);
        count_high(2, 32, h);
        check("R5 divide by 4", h, 16);
        wr(pair_a(2), 32'h9);
        cfg(2, 1, 0, 1, 1);
        repeat (7) @(negedge clk);
        count_high(2, 1024, h);
        check("R5 exponent 9 acts as 8", h, 512);
    endtask

    task automatic t_source;
        int h;
        wr(pair_a(3), 32'h80);
        cfg(3, 1, 0, 3, 1);
        repeat (6) @(negedge clk);
        count_high(3, 32, h);
        check("R6 second source selected", h, 8);
        count_high(2, 32, h);
        check("R2 pair word shared by ch2", h, 16);
    endtask

    task automatic t_polarity;
        int h;
        cfg(0, 0, 0, 9, 3);
        repeat (5) @(negedge clk);
        count_high(0, 40, h);
        check("R7 active low duty", h, 28);
    endtask

    task automatic t_extremes;
        int h;
        cfg(0, 1, 0, 9, 0);
        repeat (5) @(negedge clk);
        count_high(0, 40, h);
        check("R8 active count zero", h, 0);
        cfg(0, 1, 0, 9, 12);
        repeat (5) @(negedge clk);
        count_high(0, 40, h);
        check("R8 active count above period", h, 40);
    endtask

    task automatic t_enable;
        int h;
        cfg(0, 1, 0, 9, 3);
        wr(12'h080, 32'hE);
        count_high(0, 20, h);
        check("R9 disabled channel inactive", h, 0);
        count_high(1, 48, h);
        check("R9 other channel still runs", h, 12);
        wr(12'h080, 32'hF);
    endtask

    task automatic t_gate;
        int h, n;
        wr(12'h040, 32'hE);
        cfg(0, 0, 0, 9, 3);
        count_high(0, 20, h);
        check("R10 ungated channel inactive", h, 20);
        wr(12'h040, 32'hF);
        run_len(0, 1'b0, n);
        check("R10 regated run starts at period start", n, 3);
    endtask

    task automatic t_restart;
        int n;
        cfg(0, 1, 0, 9, 3);
        while (pwm_out[0] != 1'b1) @(negedge clk);
        while (pwm_out[0] != 1'b0) @(negedge clk);
        wr(per_a(0), {16'd9, 16'd3});
        check("R11 active right after rewrite", pwm_out[0], 1);
        run_len(0, 1'b1, n);
        check("R11 fresh active phase length", n, 3);
    endtask

    task automatic t_readback;
        wr(ctl_a(2), 32'hFFFF_FFFF);
        rd_check("R12 control word mask", ctl_a(2), 32'h1FF);
        wr(pair_a(0), 32'hFFFF_FFFF);
        rd_check("R12 pair word mask", pair_a(0), 32'h8F);
        wr(12'h080, 32'hFFFF_FFF5);
        rd_check("R12 enable word mask", 12'h080, 32'h5);
        wr(per_a(3), 32'hDEAD_BEEF);
        rd_check("R12 period word", per_a(3), 32'hDEAD_BEEF);
        rd_check("R12 unmapped address", 12'h0F0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_duty();
        t_prescale();
        t_divider();
        t_source();
        t_polarity();
        t_extremes();
        t_enable();
        t_gate();
        t_restart();
        t_readback();
        finish_run();
    end
endmodule